// File: doc/BRIEF.md
# Immediate-Offset Word Load Decoder

This block is a purely combinational decoder for the immediate-offset form of a word load. It takes one 32-bit instruction word and a mode bit that selects between two instruction sets. One set uses a fixed-width 32-bit word. The other, compact set uses 16-bit instructions and two-halfword instructions. The decoder recognises the five bit layouts that encode this load. For each layout it returns the destination register, the base register, a zero-extended byte offset and the addressing controls: pre/post indexing, add/subtract and base writeback.

Next to the decoded fields it classifies each recognised pattern. The pattern is either a clean match, or an encoding that has to be redirected to the PC-relative literal decoder, or one redirected to the unprivileged-load decoder, or an undefined encoding. A separate unpredictable flag marks a match whose operand choice gives no defined result. Two status inputs describe the surrounding conditional-execution block: whether the instruction sits inside such a block, and whether it is the last instruction there. The instruction-fetch logic supplies both. Every other opcode gives no flag at all.

Top module: `ldi_dec`

## Requirements
- R1: With the mode bit low, a word is recognised when bits[31:28] are not 1111, bits[27:25] are 010, bit22 is 0 and bit20 is 1. Bit24 is P, bit23 is U, bit21 is W, [19:16] is the base, [15:12] is the destination and [11:0] is the offset. The outputs are index=P, add=U and wback=(not P) or W.
- R2: For a word recognised under R1, a base of 15 raises only the literal redirect. Otherwise P=0 with W=1 raises only the unprivileged redirect. Any other combination raises match.
- R3: With the mode bit high, the first halfword sits in instr[31:16] and the second halfword in instr[15:0]. A 16-bit instruction uses only instr[31:16]. When instr[31:27]=01101, the offset is instr[26:22] times 4, the base is instr[21:19] and the destination is instr[18:16]. The outputs are index=1, add=1 and wback=0, and instr[15:0] has no effect.
- R4: With the mode bit high and instr[31:27]=10011, the destination is instr[26:24], the base is fixed at 13 and the offset is instr[23:16] times 4. The outputs are index=1, add=1 and wback=0.
- R5: With the mode bit high and instr[31:20]=111110001101, the base is instr[19:16], the destination is instr[15:12] and the offset is instr[11:0]. The outputs are index=1, add=1 and wback=0. A base of 15 raises only the literal redirect.
- R6: With the mode bit high, instr[31:20]=111110000101 and instr[11]=1, the base is instr[19:16] and the destination is instr[15:12]. The controls come from P=instr[10], U=instr[9] and W=instr[8], giving index=P, add=U and wback=W. The offset is instr[7:0]. If instr[11] is 0, nothing is recognised.
- R7: For the layout of R6, the checks apply in this order. A base of 15 raises the literal redirect. Otherwise P=1, U=1, W=0 raises the unprivileged redirect. Otherwise P=0, W=0 raises undefined. Any other combination raises match.
- R8: A match with wback=1 whose base equals its destination raises unpredictable.
- R9: A match in either two-halfword layout (R5, R6) with destination 15 raises unpredictable when the inside-block input is 1 and the last-in-block input is 0.
- R10: At most one of match, literal redirect, unprivileged redirect and undefined is high. Unpredictable is only ever high together with match. When match is low, the destination, base, offset, index, add and wback outputs are all zero. A word that matches no layout of the selected mode, including any fixed-width word presented in compact mode, raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word; in compact mode the first halfword is in [31:16] |
| compact_i | input | 1 | 1 selects the compact set, 0 selects the fixed-width set |
| in_blk_i | input | 1 | Instruction is inside a conditional-execution block |
| last_blk_i | input | 1 | Instruction is the last one of that block |
| match_o | output | 1 | Clean decode of an immediate-offset word load |
| lit_redir_o | output | 1 | Encoding belongs to the literal-load decoder |
| unpriv_redir_o | output | 1 | Encoding belongs to the unprivileged-load decoder |
| undef_o | output | 1 | Undefined encoding |
| unpred_o | output | 1 | Match with no defined result |
| rt_o | output | 4 | Destination register number |
| rn_o | output | 4 | Base register number |
| offset_o | output | OFF_W | Zero-extended byte offset |
| index_o | output | 1 | Offset applied before the access |
| add_o | output | 1 | Offset is added (1) or subtracted (0) |
| wback_o | output | 1 | Base register is updated |

## Verification
The bench builds the decoder with OFF_W=32 and the fixed base at 13. At that width, every offset bit above the 12-bit field must read as zero, which exposes any sign extension or any misplaced scaling shift. The fixed base of 13 can be told apart from every encoded 3-bit base, so a wrong base mux in the second 16-bit layout is caught. Directed vectors cover each priority step of the redirect and undefined rules. Random words built around each opcode prefix then cover the operand collisions and block-status combinations.

// File: rtl/ldi_pkg.sv
package ldi_pkg;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned HALF_W = INSN_W / 2;
  localparam int unsigned IMM_W  = 12;

  // variant selectors for the compact-set sub-decoders
  localparam int unsigned SHORT_REG  = 0;
  localparam int unsigned SHORT_SP   = 1;
  localparam int unsigned N_SHORT    = 2;
  localparam int unsigned PAIR_PLAIN = 0;
  localparam int unsigned PAIR_IDX   = 1;
  localparam int unsigned N_PAIR     = 2;

  localparam logic [REG_W-1:0] PC_IDX = '1;

  typedef struct packed {
    logic             hit;
    logic             lit;
    logic             upv;
    logic             udf;
    logic             unp;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] rn;
    logic [IMM_W-1:0] imm;
    logic             idx;
    logic             add;
    logic             wb;
  } ldi_res_t;

  localparam int unsigned RES_W = $bits(ldi_res_t);
endpackage

// File: rtl/ldi_wide_dec.sv
module ldi_wide_dec
  import ldi_pkg::*;
(
  input  logic [INSN_W-1:0] word_i,
  output ldi_res_t          res_o
);
  logic             p, u, w, wb, opc_ok;
  logic [REG_W-1:0] rn, rt;

  assign p  = word_i[24];
  assign u  = word_i[23];
  assign w  = word_i[21];
  assign rn = word_i[19:16];
  assign rt = word_i[15:12];
  assign wb = ~p | w;
  assign opc_ok = (word_i[31:28] != 4'hF) && (word_i[27:25] == 3'b010)
                  && !word_i[22] && word_i[20];

  always_comb begin
    res_o = '0;
    if (opc_ok) begin
      if (rn == PC_IDX) begin
        res_o.lit = 1'b1;
      end else if (!p && w) begin
        res_o.upv = 1'b1;
      end else begin
        res_o.hit = 1'b1;
        res_o.rt  = rt;
        res_o.rn  = rn;
        res_o.imm = word_i[11:0];
        res_o.idx = p;
        res_o.add = u;
        res_o.wb  = wb;
        res_o.unp = wb && (rn == rt);
      end
    end
  end
endmodule

// File: rtl/ldi_short_dec.sv
module ldi_short_dec
  import ldi_pkg::*;
#(
  parameter int unsigned FORM   = SHORT_REG,
  parameter int unsigned SP_IDX = 13
) (
  input  logic [HALF_W-1:0] half_i,
  output ldi_res_t          res_o
);
  generate
    if (FORM == SHORT_REG) begin : g_reg
      always_comb begin
        res_o = '0;
        if (half_i[15:11] == 5'b01101) begin
          res_o.hit = 1'b1;
          res_o.rt  = REG_W'(half_i[2:0]);
          res_o.rn  = REG_W'(half_i[5:3]);
          res_o.imm = IMM_W'({half_i[10:6], 2'b00});
          res_o.idx = 1'b1;
          res_o.add = 1'b1;
        end
      end
    end else begin : g_sp
      always_comb begin
        res_o = '0;
        if (half_i[15:11] == 5'b10011) begin
          res_o.hit = 1'b1;
          res_o.rt  = REG_W'(half_i[10:8]);
          res_o.rn  = REG_W'(SP_IDX);
          res_o.imm = IMM_W'({half_i[7:0], 2'b00});
          res_o.idx = 1'b1;
          res_o.add = 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ldi_pair_dec.sv
module ldi_pair_dec
  import ldi_pkg::*;
#(
  parameter int unsigned FORM = PAIR_PLAIN
) (
  input  logic [HALF_W-1:0] hw1_i,
  input  logic [HALF_W-1:0] hw2_i,
  input  logic              in_blk_i,
  input  logic              last_blk_i,
  output ldi_res_t          res_o
);
  logic [REG_W-1:0] rn, rt;
  logic             pc_hazard;

  assign rn = hw1_i[3:0];
  assign rt = hw2_i[15:12];
  // destination PC only allowed outside a block or at its end
  assign pc_hazard = (rt == PC_IDX) && in_blk_i && !last_blk_i;

  generate
    if (FORM == PAIR_PLAIN) begin : g_plain
      always_comb begin
        res_o = '0;
        if (hw1_i[15:4] == 12'hF8D) begin
          if (rn == PC_IDX) begin
            res_o.lit = 1'b1;
          end else begin
            res_o.hit = 1'b1;
            res_o.rt  = rt;
            res_o.rn  = rn;
            res_o.imm = hw2_i[11:0];
            res_o.idx = 1'b1;
            res_o.add = 1'b1;
            res_o.unp = pc_hazard;
          end
        end
      end
    end else begin : g_idx
      logic p, u, w;
      assign p = hw2_i[10];
      assign u = hw2_i[9];
      assign w = hw2_i[8];
      always_comb begin
        res_o = '0;
        if ((hw1_i[15:4] == 12'hF85) && hw2_i[11]) begin
          if (rn == PC_IDX) begin
            res_o.lit = 1'b1;
          end else if (p && u && !w) begin
            res_o.upv = 1'b1;
          end else if (!p && !w) begin
            res_o.udf = 1'b1;
          end else begin
            res_o.hit = 1'b1;
            res_o.rt  = rt;
            res_o.rn  = rn;
            res_o.imm = IMM_W'(hw2_i[7:0]);
            res_o.idx = p;
            res_o.add = u;
            res_o.wb  = w;
            res_o.unp = (w && (rn == rt)) || pc_hazard;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ldi_dec.sv
module ldi_dec
  import ldi_pkg::*;
#(
  parameter int unsigned OFF_W  = 32,
  parameter int unsigned SP_IDX = 13
) (
  input  logic [INSN_W-1:0] instr_i,
  input  logic              compact_i,
  input  logic              in_blk_i,
  input  logic              last_blk_i,
  output logic              match_o,
  output logic              lit_redir_o,
  output logic              unpriv_redir_o,
  output logic              undef_o,
  output logic              unpred_o,
  output logic [REG_W-1:0]  rt_o,
  output logic [REG_W-1:0]  rn_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              index_o,
  output logic              add_o,
  output logic              wback_o
);
  localparam int unsigned N_CAND = 1 + N_SHORT + N_PAIR;

  logic [HALF_W-1:0] hw1, hw2;
  logic              is_pair;
  ldi_res_t          wide_res;
  ldi_res_t          short_res [N_SHORT];
  ldi_res_t          pair_res  [N_PAIR];
  logic [RES_W-1:0]  cand      [N_CAND];
  logic [RES_W-1:0]  merged;
  ldi_res_t          res;

  assign hw1 = instr_i[INSN_W-1:HALF_W];
  assign hw2 = instr_i[HALF_W-1:0];
  // leading 111 with a nonzero next pair marks a two-halfword instruction
  assign is_pair = (hw1[15:13] == 3'b111) && (hw1[12:11] != 2'b00);

  ldi_wide_dec u_wide (
    .word_i (instr_i),
    .res_o  (wide_res)
  );

  generate
    for (genvar k = 0; k < N_SHORT; k++) begin : g_short
      ldi_short_dec #(
        .FORM   (k),
        .SP_IDX (SP_IDX)
      ) u_short (
        .half_i (hw1),
        .res_o  (short_res[k])
      );
      assign cand[1+k] = (compact_i && !is_pair) ? short_res[k] : '0;
    end

    for (genvar k = 0; k < N_PAIR; k++) begin : g_pair
      ldi_pair_dec #(
        .FORM (k)
      ) u_pair (
        .hw1_i      (hw1),
        .hw2_i      (hw2),
        .in_blk_i   (in_blk_i),
        .last_blk_i (last_blk_i),
        .res_o      (pair_res[k])
      );
      assign cand[1+N_SHORT+k] = (compact_i && is_pair) ? pair_res[k] : '0;
    end
  endgenerate

  assign cand[0] = compact_i ? '0 : wide_res;

  // opcode prefixes are disjoint, so at most one candidate is nonzero
  always_comb begin
    merged = '0;
    for (int k = 0; k < N_CAND; k++) merged = merged | cand[k];
  end

  assign res            = ldi_res_t'(merged);
  assign match_o        = res.hit;
  assign lit_redir_o    = res.lit;
  assign unpriv_redir_o = res.upv;
  assign undef_o        = res.udf;
  assign unpred_o       = res.unp;
  assign rt_o           = res.rt;
  assign rn_o           = res.rn;
  assign offset_o       = OFF_W'(res.imm);
  assign index_o        = res.idx;
  assign add_o          = res.add;
  assign wback_o        = res.wb;
endmodule

// File: rtl/ldi_dec_chk.sv
module ldi_dec_chk
  import ldi_pkg::*;
#(
  parameter int unsigned OFF_W  = 32,
  parameter int unsigned SP_IDX = 13
) (
  input logic [INSN_W-1:0] instr_i,
  input logic              compact_i,
  input logic              in_blk_i,
  input logic              last_blk_i,
  input logic              match_o,
  input logic              lit_redir_o,
  input logic              unpriv_redir_o,
  input logic              undef_o,
  input logic              unpred_o,
  input logic [REG_W-1:0]  rt_o,
  input logic [REG_W-1:0]  rn_o,
  input logic [OFF_W-1:0]  offset_o,
  input logic              index_o,
  input logic              add_o,
  input logic              wback_o
);
  always_comb begin
    a_r10_one_class: assert ($countones({match_o, lit_redir_o, unpriv_redir_o, undef_o}) <= 1)
      else $error("class flags not exclusive");
    a_r10_unpred_with_match: assert (!unpred_o || match_o)
      else $error("unpredictable without match");
    a_r10_idle_fields: assert (match_o || (rt_o == '0 && rn_o == '0 && offset_o == '0
                                          && !index_o && !add_o && !wback_o))
      else $error("fields active without match");
    a_r1_post_index_writes: assert (!(match_o && !index_o) || wback_o)
      else $error("post-indexed match without writeback");
    a_r3_short_controls: assert (!(compact_i && match_o && instr_i[31:29] != 3'b111)
                                 || (index_o && add_o && !wback_o))
      else $error("16-bit form with wrong controls");
    a_r4_fixed_base: assert (!(compact_i && match_o && instr_i[31:27] == 5'b10011)
                             || rn_o == REG_W'(SP_IDX))
      else $error("fixed base not applied");
    a_r8_wb_collision: assert (!(match_o && wback_o && rn_o == rt_o) || unpred_o)
      else $error("writeback collision not flagged");
    a_r9_block_pc: assert (!(compact_i && match_o && instr_i[31:29] == 3'b111 && rt_o == PC_IDX
                             && in_blk_i && !last_blk_i) || unpred_o)
      else $error("PC destination inside block not flagged");
    a_r10_wide_hidden: assert (!compact_i || !(instr_i[27:25] == 3'b010 && instr_i[31:29] != 3'b111
                               && instr_i[31:27] != 5'b01101 && instr_i[31:27] != 5'b10011)
                               || !(match_o || lit_redir_o || unpriv_redir_o || undef_o))
      else $error("fixed-width word decoded in compact mode");
  end
endmodule

bind ldi_dec ldi_dec_chk #(.OFF_W(OFF_W), .SP_IDX(SP_IDX)) u_chk (.*);

// File: tb/ldi_dec_bench.sv
module ldi_dec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr;
  logic        compact, in_blk, last_blk;
  logic        match, lit, upv, udf, unp, idx, add, wb;
  logic [3:0]  rt, rn;
  logic [31:0] off;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldi_dec u_ldi_dec (
    .instr_i        (instr),
    .compact_i      (compact),
    .in_blk_i       (in_blk),
    .last_blk_i     (last_blk),
    .match_o        (match),
    .lit_redir_o    (lit),
    .unpriv_redir_o (upv),
    .undef_o        (udf),
    .unpred_o       (unp),
    .rt_o           (rt),
    .rn_o           (rn),
    .offset_o       (off),
    .index_o        (idx),
    .add_o          (add),
    .wback_o        (wb)
  );

  // behavioural reference: {match,lit,upv,udf,unp,rt,rn,off,idx,add,wb}
  function automatic logic [47:0] model(input logic [31:0] w, input logic c,
                                        input logic ib, input logic lb);
    int m = 0, l = 0, u = 0, d = 0, x = 0, t = 0, n = 0, o = 0, pi = 0, pa = 0, pw = 0;
    int h1 = int'(w >> 16);
    int h2 = int'(w & 32'hFFFF);
    if (!c) begin
      if ((w >> 28) != 15 && ((w >> 25) & 7) == 2 && !w[22] && w[20]) begin
        n = (w >> 16) & 15;
        if (n == 15) l = 1;
        else if (!w[24] && w[21]) u = 1;
        else begin
          m = 1; t = (w >> 12) & 15; o = w & 12'hFFF;
          pi = w[24]; pa = w[23]; pw = (!w[24] || w[21]) ? 1 : 0;
        end
      end
    end else if ((h1 >> 11) == 13) begin
      m = 1; t = h1 & 7; n = (h1 >> 3) & 7; o = ((h1 >> 6) & 31) * 4; pi = 1; pa = 1;
    end else if ((h1 >> 11) == 19) begin
      m = 1; t = (h1 >> 8) & 7; n = 13; o = (h1 & 255) * 4; pi = 1; pa = 1;
    end else if ((h1 >> 4) == 'hF8D) begin
      n = h1 & 15;
      if (n == 15) l = 1;
      else begin m = 1; t = h2 >> 12; o = h2 & 4095; pi = 1; pa = 1; end
    end else if ((h1 >> 4) == 'hF85 && w[11]) begin
      n = h1 & 15;
      if (n == 15) l = 1;
      else if (w[10] && w[9] && !w[8]) u = 1;
      else if (!w[10] && !w[8]) d = 1;
      else begin m = 1; t = h2 >> 12; o = h2 & 255; pi = w[10]; pa = w[9]; pw = w[8]; end
    end
    if (m == 1) begin
      if (pw == 1 && n == t) x = 1;
      if (c && (h1 >> 13) == 7 && t == 15 && ib && !lb) x = 1;
    end else begin
      n = 0;
    end
    return {m[0], l[0], u[0], d[0], x[0], t[3:0], n[3:0], o[31:0], pi[0], pa[0], pw[0]};
  endfunction

  task automatic run(input logic [31:0] w, input logic c, input logic ib,
                     input logic lb, input string tag);
    logic [47:0] exp_v, got_v;
    @(negedge clk);
    instr = w; compact = c; in_blk = ib; last_blk = lb;
    @(posedge clk);
    #1;
    exp_v = model(w, c, ib, lb);
    got_v = {match, lit, upv, udf, unp, rt, rn, off, idx, add, wb};
    checks++;
    if (got_v !== exp_v) begin
      errors++;
      $display("FAIL %s instr=%h c=%0b got=%h exp=%h", tag, w, c, got_v, exp_v);
    end
  endtask

  function automatic logic [31:0] f_wide(logic [3:0] cnd, logic p, logic u, logic w,
                                         logic [3:0] bn, logic [3:0] dt, logic [11:0] im);
    return {cnd, 3'b010, p, u, 1'b0, w, 1'b1, bn, dt, im};
  endfunction
  function automatic logic [31:0] f_sa(logic [4:0] im, logic [2:0] bn, logic [2:0] dt,
                                       logic [15:0] junk);
    return {5'b01101, im, bn, dt, junk};
  endfunction
  function automatic logic [31:0] f_sb(logic [2:0] dt, logic [7:0] im);
    return {5'b10011, dt, im, 16'h5A5A};
  endfunction
  function automatic logic [31:0] f_pc(logic [3:0] bn, logic [3:0] dt, logic [11:0] im);
    return {12'hF8D, bn, dt, im};
  endfunction
  function automatic logic [31:0] f_pd(logic [3:0] bn, logic [3:0] dt, logic b11,
                                       logic p, logic u, logic w, logic [7:0] im);
    return {12'hF85, bn, dt, b11, p, u, w, im};
  endfunction

  initial begin
    instr = '0; compact = 1'b0; in_blk = 1'b0; last_blk = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    run(32'h0, 1'b0, 1'b0, 1'b0, "R10 idle word");
    // R1 fixed-width addressing modes
    run(f_wide(4'hE, 1, 1, 1, 4'd2, 4'd3, 12'hABC), 0, 0, 0, "R1 pre-index");
    run(f_wide(4'h0, 1, 0, 0, 4'd7, 4'd1, 12'hFFF), 0, 0, 0, "R1 offset subtract");
    run(f_wide(4'h5, 0, 1, 0, 4'd9, 4'd4, 12'h001), 0, 0, 0, "R1 post-index");
    run(f_wide(4'hF, 1, 1, 0, 4'd2, 4'd3, 12'h010), 0, 0, 0, "R1 cond 1111 rejected");
    // R2 redirects
    run(f_wide(4'hE, 0, 1, 1, 4'd15, 4'd3, 12'h010), 0, 0, 0, "R2 literal wins");
    run(f_wide(4'hE, 0, 1, 1, 4'd6, 4'd3, 12'h010), 0, 0, 0, "R2 unprivileged");
    // R10 mode bit hides the fixed-width set
    run(f_wide(4'hE, 1, 1, 0, 4'd2, 4'd3, 12'h123), 1, 0, 0, "R10 wide in compact");
    run(f_sa(5'd3, 3'd1, 3'd2, 16'h0000), 0, 0, 0, "R10 short in wide mode");
    // R3 / R4 16-bit layouts
    run(f_sa(5'd31, 3'd7, 3'd5, 16'hA5A5), 1, 0, 0, "R3 max imm5");
    run(f_sa(5'd31, 3'd7, 3'd5, 16'h1234), 1, 1, 0, "R3 low half ignored");
    run(f_sb(3'd6, 8'hFF), 1, 0, 0, "R4 max imm8 fixed base");
    run(f_sb(3'd5, 8'h00), 1, 1, 0, "R4 zero offset");
    // R5 plain two-halfword
    run(f_pc(4'd4, 4'd9, 12'hFFF), 1, 0, 0, "R5 max imm12");
    run(f_pc(4'd15, 4'd9, 12'h004), 1, 0, 0, "R5 literal");
    // R6 / R7 indexed two-halfword
    run(f_pd(4'd3, 4'd8, 1, 1, 0, 0, 8'h80), 1, 0, 0, "R6 negative offset");
    run(f_pd(4'd3, 4'd8, 1, 0, 1, 1, 8'h04), 1, 0, 0, "R6 post-index");
    run(f_pd(4'd3, 4'd8, 1, 1, 1, 1, 8'hFF), 1, 0, 0, "R6 pre-index");
    run(f_pd(4'd3, 4'd8, 0, 1, 1, 1, 8'hFF), 1, 0, 0, "R6 bit11 clear");
    run(f_pd(4'd3, 4'd8, 1, 1, 1, 0, 8'h10), 1, 0, 0, "R7 unprivileged");
    run(f_pd(4'd3, 4'd8, 1, 0, 1, 0, 8'h10), 1, 0, 0, "R7 undefined");
    run(f_pd(4'd15, 4'd8, 1, 0, 1, 0, 8'h10), 1, 0, 0, "R7 literal first");
    // R8 writeback collision
    run(f_wide(4'hE, 0, 1, 0, 4'd5, 4'd5, 12'h004), 0, 0, 0, "R8 wide post collide");
    run(f_wide(4'hE, 1, 1, 0, 4'd5, 4'd5, 12'h004), 0, 0, 0, "R8 no wb no flag");
    run(f_pd(4'd6, 4'd6, 1, 1, 1, 1, 8'h04), 1, 0, 0, "R8 pair collide");
    run(f_pc(4'd6, 4'd6, 12'h004), 1, 0, 0, "R8 plain no flag");
    // R9 PC destination inside a block
    run(f_pc(4'd2, 4'd15, 12'h008), 1, 1, 0, "R9 inside not last");
    run(f_pc(4'd2, 4'd15, 12'h008), 1, 1, 1, "R9 last in block");
    run(f_pc(4'd2, 4'd15, 12'h008), 1, 0, 0, "R9 outside block");
    run(f_pd(4'd2, 4'd15, 1, 1, 0, 1, 8'h08), 1, 1, 0, "R9 indexed inside");
    run(f_wide(4'hE, 1, 1, 0, 4'd2, 4'd15, 12'h008), 0, 1, 0, "R9 wide unaffected");

    for (int i = 0; i < N_RAND; i++) begin
      logic [31:0] r = $urandom;
      logic        c = 1'b1;
      case ($urandom_range(0, 5))
        0: begin r[27:25] = 3'b010; r[22] = 1'b0; r[20] = 1'b1; c = 1'b0; end
        1: r[31:27] = 5'b01101;
        2: r[31:27] = 5'b10011;
        3: r[31:20] = 12'hF8D;
        4: r[31:20] = 12'hF85;
        default: c = $urandom_range(0, 1) == 1;
      endcase
      if ($urandom_range(0, 3) == 0) r[19:16] = r[15:12];
      run(r, c, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, "R10 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule